// File: doc/BRIEF.md
# Instruction Cache Line Fill and Prefetch Controller

This block sequences line fills for an instruction cache. An initiator that misses raises a request with the burst address it needs. The controller looks up the target set through a tag lookup port and picks a way. If every way of the set is valid, it first evicts a way chosen by a configuration input. It then claims the line: it writes the tag with the valid state cleared. After that it reads the line from the next memory level, one burst at a time.

The burst holding the missed address is read first. The cycle after that burst completes, the initiator gets a one-cycle release and can continue. The rest of the line then fills in the background in wrapping order. The valid state is set once the last burst has arrived. After the demand line, a configurable number of sequential next-line prefetches follow. Lines already present are skipped. A new miss pre-empts prefetch at the next burst boundary.

Data movement, the tag array and bus protocol sit outside. The block only drives addresses, strobes and the way to write.

Top module: `ifill_ctrl`

## Requirements
- R1: Only an asserted `miss_req` starts activity. While idle with no request, the block stays idle and all strobes, `rd_req` and `miss_rel` are low, which is also their state after reset.
- R2: On acceptance, the missed line is presented on `cur_line` for lookup. If any bit of `lk_valid` is 0, the lowest-numbered invalid way is chosen. `tag_clr` pulses for one cycle with that way on `cur_way`, and `rd_req` rises the next cycle.
- R3: If all bits of `lk_valid` are 1, `ev_stb` pulses for one cycle with `cur_way` equal to `cfg_victim`, and `tag_clr` for the same way and line follows in the next cycle.
- R4: The first burst read is the missed one (`rd_addr` = {line, burst index, zero byte offset}) with `rd_pf` low. `miss_rel` is a one-cycle pulse in the cycle after that burst's `rd_done`.
- R5: The other bursts of a demand line follow in wrapping order (index+1, +2, +3 modulo 4) with `rd_pf` high. `rd_req` and `rd_addr` hold steady until `rd_done`.
- R6: `vld_set` pulses once, for the line's way and line, in the cycle after the `rd_done` of its last burst, and never for a line that was not fully read.
- R7: `cfg_pf_depth` (0 to 3) is sampled when a miss is accepted. That many sequential next lines (line+1, wrapping at the top of the line address space) are fetched from burst 0 with `rd_pf` high, and 0 fetches none.
- R8: A prefetch line for which `lk_hit` is high during lookup is skipped, with no evict, claim, read or valid strobe, and still counts against the prefetch depth.
- R9: A miss raised during prefetch reads lets the burst in flight complete, abandons the rest of that line (no `vld_set`), and is looked up in the next cycle. Its own prefetch depth replaces the old one.
- R10: A miss raised while the rest of a demand line is filling waits until that line is sealed and is then served, replacing the earlier miss's pending prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | Miss request, held until `miss_rel` |
| miss_baddr | input | 19 | Burst address of the miss: {line, burst index} |
| miss_rel | output | 1 | One-cycle release to the initiator |
| cfg_pf_depth | input | 2 | Number of next-line prefetches |
| cfg_victim | input | 2 | Way evicted when the set is full |
| cur_line | output | 17 | Line under lookup / being filled |
| cur_way | output | 2 | Way used by the strobes and fill |
| lk_valid | input | 4 | Valid bits of the set of `cur_line` |
| lk_hit | input | 1 | `cur_line` already present |
| ev_stb | output | 1 | Evict strobe for `cur_way` |
| tag_clr | output | 1 | Write tag of `cur_line`, valid cleared |
| vld_set | output | 1 | Set valid for `cur_way` / `cur_line` |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | 24 | Burst-aligned byte address |
| rd_pf | output | 1 | Burst is not the missed one |
| rd_done | input | 1 | Requested burst written |

## Verification
The fill is driven with a partly valid set and a missed burst in mid-line, which separates lowest-free way choice from wrapping order. A full set with a miss on the top line address tells eviction apart from plain allocation and checks prefetch wrap to line 0. A prefetch target that hits shows skipping versus fetching. Two overlapping-miss patterns, one during prefetch and one during the tail of a demand line, separate abort at a burst boundary from deferral until the line is sealed.

// File: rtl/ifill_pkg.sv
package ifill_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_EVICT,
      ST_CLAIM,
      ST_FETCH,
      ST_SEAL
   } fill_st_e;
endpackage

// File: rtl/ifill_way_pick.sv
module ifill_way_pick #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0]  way_vld,
   input  logic [WAY_W-1:0] victim,
   output logic [WAY_W-1:0] way_sel,
   output logic             set_full
);
   logic [WAY_W-1:0] free_idx;

   initial begin
      assert (WAYS >= 2 && (1 << WAY_W) == WAYS)
         else $error("ifill_way_pick: WAYS must be a power of two >= 2");
   end

   generate
      if (WAYS == 2) begin : g_two
         // way 1 is free first only when way 0 is taken
         assign free_idx = way_vld[0];
      end else begin : g_many
         always_comb begin
            free_idx = '0;
            for (int i = WAYS - 1; i >= 0; i--) begin
               if (!way_vld[i]) free_idx = WAY_W'(i);
            end
         end
      end
   endgenerate

   assign set_full = &way_vld;
   assign way_sel  = set_full ? victim : free_idx;
endmodule

// File: rtl/ifill_burst_seq.sv
module ifill_burst_seq #(
   parameter int LINE_BURSTS = 4,
   parameter int BSEL_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BSEL_W-1:0] start,
   input  logic              step,
   output logic [BSEL_W-1:0] bsel,
   output logic              first_beat,
   output logic              last_beat
);
   logic [BSEL_W-1:0] base_q;
   logic [BSEL_W-1:0] cnt_q;

   initial begin
      assert (LINE_BURSTS >= 2 && (1 << BSEL_W) == LINE_BURSTS)
         else $error("ifill_burst_seq: LINE_BURSTS must be a power of two >= 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         base_q <= start;
         cnt_q  <= '0;
      end else if (step) begin
         cnt_q  <= cnt_q + BSEL_W'(1);
      end
   end

   // power-of-two line: the sum wraps inside the line by itself
   assign bsel       = base_q + cnt_q;
   assign first_beat = (cnt_q == '0);
   assign last_beat  = (cnt_q == BSEL_W'(LINE_BURSTS - 1));

   AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last_beat && !load) |=> (bsel == $past(bsel) + BSEL_W'(1))); // R5
endmodule

// File: rtl/ifill_ctrl.sv
module ifill_ctrl
   import ifill_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int BURST_BYTES = 32,
   parameter int LINE_BURSTS = 4,
   parameter int WAYS        = 4,
   parameter int PF_MAX      = 3,
   localparam int BOFF_W     = $clog2(BURST_BYTES),
   localparam int BSEL_W     = $clog2(LINE_BURSTS),
   localparam int LINE_W     = ADDR_W - BOFF_W - BSEL_W,
   localparam int BADDR_W    = LINE_W + BSEL_W,
   localparam int WAY_W      = $clog2(WAYS),
   localparam int PFC_W      = $clog2(PF_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               miss_req,
   input  logic [BADDR_W-1:0] miss_baddr,
   output logic               miss_rel,
   input  logic [PFC_W-1:0]   cfg_pf_depth,
   input  logic [WAY_W-1:0]   cfg_victim,
   output logic [LINE_W-1:0]  cur_line,
   output logic [WAY_W-1:0]   cur_way,
   input  logic [WAYS-1:0]    lk_valid,
   input  logic               lk_hit,
   output logic               ev_stb,
   output logic               tag_clr,
   output logic               vld_set,
   output logic               rd_req,
   output logic [ADDR_W-1:0]  rd_addr,
   output logic               rd_pf,
   input  logic               rd_done
);
   fill_st_e           st, st_d;
   logic [LINE_W-1:0]  line_q;
   logic [BSEL_W-1:0]  first_q;
   logic               demand_q;
   logic [PFC_W-1:0]   pf_left;
   logic [PFC_W-1:0]   pf_start;
   logic [WAY_W-1:0]   way_q;
   logic               rel_q;

   logic [WAY_W-1:0]   pick_way;
   logic               set_full;
   logic [BSEL_W-1:0]  bsel;
   logic               first_beat, last_beat;
   logic               fetch_done, take, adv, pick, pf_more, pf_hit;

   initial begin
      assert (LINE_W > 0 && PF_MAX >= 0 && BURST_BYTES >= 2 && (1 << BOFF_W) == BURST_BYTES)
         else $error("ifill_ctrl: bad geometry parameters");
   end

   generate
      if (PF_MAX < (1 << PFC_W) - 1) begin : g_clamp
         assign pf_start = (cfg_pf_depth > PFC_W'(PF_MAX)) ? PFC_W'(PF_MAX) : cfg_pf_depth;
      end else begin : g_direct
         assign pf_start = cfg_pf_depth;
      end
   endgenerate

   ifill_way_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) i_pick (
      .way_vld  (lk_valid),
      .victim   (cfg_victim),
      .way_sel  (pick_way),
      .set_full (set_full)
   );

   ifill_burst_seq #(.LINE_BURSTS(LINE_BURSTS), .BSEL_W(BSEL_W)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (st == ST_CLAIM),
      .start      (first_q),
      .step       (fetch_done),
      .bsel       (bsel),
      .first_beat (first_beat),
      .last_beat  (last_beat)
   );

   assign fetch_done = (st == ST_FETCH) && rd_done;
   assign pf_more    = (pf_left != '0);
   assign pf_hit     = !demand_q && lk_hit;

   // points where a fresh miss may be taken
   assign take = miss_req && ((st == ST_IDLE)
                           || (st == ST_LOOK && !demand_q)
                           || (fetch_done && !demand_q && !last_beat)
                           || (st == ST_SEAL));
   assign adv  = !take && pf_more
              && ((st == ST_LOOK && pf_hit) || (st == ST_SEAL));
   assign pick = !take && (st == ST_LOOK) && !pf_hit;

   always_comb begin
      st_d = st;
      case (st)
         ST_IDLE:  if (take) st_d = ST_LOOK;
         ST_LOOK: begin
            if (take)        st_d = ST_LOOK;
            else if (pf_hit) st_d = pf_more ? ST_LOOK : ST_IDLE;
            else             st_d = set_full ? ST_EVICT : ST_CLAIM;
         end
         ST_EVICT: st_d = ST_CLAIM;
         ST_CLAIM: st_d = ST_FETCH;
         ST_FETCH: begin
            if (rd_done) begin
               if (last_beat) st_d = ST_SEAL;
               else if (take) st_d = ST_LOOK;
            end
         end
         ST_SEAL:  st_d = (take || pf_more) ? ST_LOOK : ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         line_q   <= '0;
         first_q  <= '0;
         demand_q <= 1'b0;
         pf_left  <= '0;
         way_q    <= '0;
         rel_q    <= 1'b0;
      end else begin
         st    <= st_d;
         rel_q <= fetch_done && demand_q && first_beat;
         if (take) begin
            line_q   <= miss_baddr[BADDR_W-1 -: LINE_W];
            first_q  <= miss_baddr[BSEL_W-1:0];
            demand_q <= 1'b1;
            pf_left  <= pf_start;
         end else if (adv) begin
            line_q   <= line_q + LINE_W'(1);
            first_q  <= '0;
            demand_q <= 1'b0;
            pf_left  <= pf_left - PFC_W'(1);
         end
         if (pick) way_q <= pick_way;
      end
   end

   assign cur_line = line_q;
   assign cur_way  = way_q;
   assign ev_stb   = (st == ST_EVICT);
   assign tag_clr  = (st == ST_CLAIM);
   assign vld_set  = (st == ST_SEAL);
   assign rd_req   = (st == ST_FETCH);
   assign rd_addr  = {line_q, bsel, {BOFF_W{1'b0}}};
   assign rd_pf    = !(demand_q && first_beat);
   assign miss_rel = rel_q;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !miss_req) |=> (st == ST_IDLE && !rd_req)); // R1
   AST_CLAIM_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      tag_clr |=> (rd_req && $stable(cur_way) && $stable(cur_line))); // R2
   AST_EVICT_TO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stb |=> (tag_clr && $stable(cur_way))); // R3
   AST_REL_AFTER_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
      miss_rel |-> $past(rd_req && rd_done && !rd_pf)); // R4
   AST_REL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      miss_rel |=> !miss_rel); // R4
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_done) |=> (rd_req && $stable(rd_addr) && $stable(rd_pf))); // R5
   AST_SEAL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      vld_set |-> $past(rd_req && rd_done)); // R6
endmodule

// File: tb/test_ifill_ctrl.sv
module test_ifill_ctrl;
   localparam int LW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_req = 1'b0;
   logic [18:0]   miss_baddr = '0;
   logic [1:0]    cfg_pf_depth = '0;
   logic [1:0]    cfg_victim = '0;
   logic [3:0]    vmask = '0;
   logic          hit_en = 1'b0;
   logic [LW-1:0] hit_line = '0;
   logic          rd_done = 1'b0;
   logic          miss_rel, ev_stb, tag_clr, vld_set, rd_req, rd_pf, lk_hit;
   logic [LW-1:0] cur_line;
   logic [1:0]    cur_way;
   logic [23:0]   rd_addr;

   int checks = 0;
   int errors = 0;
   int read_seen = 0;
   int lat = 0;
   bit prev_dem = 1'b0;
   bit rec_dem;
   int cycles = 0;

   logic [43:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   assign lk_hit = hit_en && (cur_line == hit_line);

   ifill_ctrl i_ifill_ctrl (
      .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_baddr(miss_baddr),
      .miss_rel(miss_rel), .cfg_pf_depth(cfg_pf_depth), .cfg_victim(cfg_victim),
      .cur_line(cur_line), .cur_way(cur_way), .lk_valid(vmask), .lk_hit(lk_hit),
      .ev_stb(ev_stb), .tag_clr(tag_clr), .vld_set(vld_set), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_pf(rd_pf), .rd_done(rd_done)
   );

   // event kinds: 1 evict, 2 claim, 3 read, 4 release, 5 valid set
   function automatic logic [43:0] ev(int k, int w, int pf, logic [31:0] v);
      return {k[3:0], w[3:0], pf[3:0], v};
   endfunction

   function automatic logic [31:0] raddr(logic [LW-1:0] l, int b);
      logic [1:0] bb = b[1:0];
      return {8'd0, l, bb, 5'd0};
   endfunction

   function automatic int exp_way(logic [3:0] vm, int vic, output bit evict);
      int w = vic;
      evict = 1'b1;
      for (int i = 3; i >= 0; i--) if (!vm[i]) begin w = i; evict = 1'b0; end
      return w;
   endfunction

   task automatic check(bit ok, string tag, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic push(logic [43:0] e, string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic got(logic [43:0] e);
      if (exp_q.size() == 0) begin
         check(1'b0, "R1", "unexpected event", e, 0);
      end else begin
         logic [43:0] x = exp_q.pop_front();
         string t = tag_q.pop_front();
         check(e == x, t, "event", e, x);
      end
   endtask

   // expected events of one line fill
   task automatic push_line(logic [LW-1:0] line, int way, bit evict, int first,
                            bit demand, int nb, bit seal);
      if (evict) push(ev(1, way, 0, 32'(line)), "R3");
      push(ev(2, way, 0, 32'(line)), "R2");
      for (int i = 0; i < nb; i++) begin
         bit dm = demand && (i == 0);
         push(ev(3, 0, dm ? 0 : 1, raddr(line, (first + i) % 4)),
              dm ? "R4" : (demand ? "R5" : "R7"));
         if (dm) push(ev(4, 0, 0, 0), "R4");
      end
      if (seal) push(ev(5, way, 0, 32'(line)), "R6");
   endtask

   // monitor and memory responder share one edge so their order is fixed
   always @(negedge clk) begin
      rec_dem = 1'b0;
      if (rst_n) begin
         if (miss_rel) begin
            check(prev_dem, "R4", "release one cycle after demand burst", 0, 1);
            got(ev(4, 0, 0, 0));
         end
         if (ev_stb)  got(ev(1, int'(cur_way), 0, 32'(cur_line)));
         if (tag_clr) got(ev(2, int'(cur_way), 0, 32'(cur_line)));
         if (vld_set) got(ev(5, int'(cur_way), 0, 32'(cur_line)));
         if (rd_done) begin
            rd_done = 1'b0;
            lat = 0;
         end else if (rd_req) begin
            lat++;
            if (lat == 2) begin
               rd_done = 1'b1;
               got(ev(3, 0, int'(rd_pf), 32'(rd_addr)));
               read_seen++;
               rec_dem = !rd_pf;
            end
         end
      end
      prev_dem = rec_dem;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic do_miss(logic [LW-1:0] line, int b, int depth);
      @(negedge clk);
      cfg_pf_depth = depth[1:0];
      miss_baddr   = {line, b[1:0]};
      miss_req     = 1'b1;
      do @(negedge clk); while (!miss_rel);
      miss_req = 1'b0;
   endtask

   task automatic drain(string t);
      wait (exp_q.size() == 0);
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0 && !rd_req && !vld_set, t, "drained and idle", exp_q.size(), 0);
   endtask

   initial begin
      bit evict;
      int w;
      int base;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!miss_rel && !rd_req && !ev_stb && !tag_clr && !vld_set, "R1", "reset outputs",
            {miss_rel, rd_req, ev_stb, tag_clr, vld_set}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check(!rd_req && !tag_clr && !ev_stb, "R1", "idle without miss", rd_req, 0);

      // R2/R4/R5: partly valid set, mid-line miss, no prefetch
      vmask = 4'b1011;
      w = exp_way(vmask, 0, evict);
      push_line(17'h00a5c, w, evict, 2, 1'b1, 4, 1'b1);
      do_miss(17'h00a5c, 2, 0);
      drain("R2");

      // R3/R7: full set, top line, prefetch wraps to line 0
      vmask = 4'b1111;
      cfg_victim = 2'd2;
      w = exp_way(vmask, 2, evict);
      push_line(17'h1ffff, w, evict, 3, 1'b1, 4, 1'b1);
      push_line(17'h00000, w, evict, 0, 1'b0, 4, 1'b1);
      do_miss(17'h1ffff, 3, 1);
      drain("R7");

      // R8: next line already present is skipped
      vmask = 4'b0001;
      hit_en = 1'b1;
      hit_line = 17'h00301;
      w = exp_way(vmask, 0, evict);
      push_line(17'h00300, w, evict, 1, 1'b1, 4, 1'b1);
      push_line(17'h00302, w, evict, 0, 1'b0, 4, 1'b1);
      do_miss(17'h00300, 1, 2);
      drain("R8");
      hit_en = 1'b0;

      // R9: miss during prefetch aborts after the burst in flight
      vmask = 4'b0000;
      push_line(17'h00100, 0, 1'b0, 1, 1'b1, 4, 1'b1);
      push_line(17'h00101, 0, 1'b0, 0, 1'b0, 2, 1'b0);
      push_line(17'h00200, 0, 1'b0, 3, 1'b1, 4, 1'b1);
      base = read_seen;
      do_miss(17'h00100, 1, 3);
      wait (read_seen == base + 5);
      do_miss(17'h00200, 3, 0);
      drain("R9");

      // R10: miss during demand line tail waits for the seal
      push_line(17'h00400, 0, 1'b0, 0, 1'b1, 4, 1'b1);
      push_line(17'h00500, 0, 1'b0, 2, 1'b1, 4, 1'b1);
      base = read_seen;
      do_miss(17'h00400, 0, 2);
      wait (read_seen == base + 2);
      do_miss(17'h00500, 2, 0);
      drain("R10");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule